// File: doc/BRIEF.md
# Framebuffer Line Fetcher

This block moves a frame of pixel data from memory into a local word FIFO that a display pipeline drains at its own pace. Software sets a base address, the frame length in 32-bit words (width times height times bits per pixel, divided by 32), a burst length and a refill threshold. It then sets the enable. The fetcher issues fixed-length read bursts on a simple request/grant master port and writes each returned beat into the FIFO. When the frame's word count is used up, it starts again at the base address.

A burst is only launched when the FIFO fill level is at or below the threshold. Setting the threshold to depth − (2 × burst + 3) keeps a full burst of headroom, so the FIFO never overflows. A single-cycle clear strobe returns the fetcher to the frame start, empties the FIFO and drops any beats still arriving for the burst in flight. Dropping the enable lets the current burst complete and then stops issuing requests. A sticky flag records any read by the display side while the FIFO is empty.

Top module: `fb_line_fetcher`

## Requirements
- R1: After reset no request is raised, the FIFO is empty with level 0, and the underflow flag is 0.
- R2: Each request address equals base + 4 × k, where k is the number of words already requested in the current frame.
- R3: `mem_len_m1` carries the burst length minus one. Every burst is `cfg_burst_m1`+1 words long, except that the last burst of a frame is cut to the words that remain.
- R4: Once `cfg_frame_words` words have been requested, the next request starts again at the base address.
- R5: A request is raised only from the idle state, and only when the FIFO level sampled on the deciding edge is at or below `cfg_threshold`. At most one burst is outstanding at a time. With no reads, the level settles at the smallest multiple of the burst length that exceeds the threshold.
- R6: A raised request, with its address and length, stays unchanged until `mem_gnt` is seen. The only exception is a clear, which withdraws it.
- R7: Beats are written to the FIFO in arrival order. `px_data` shows the oldest word, and `px_pop` removes it.
- R8: A one-cycle `cfg_dma_clear` empties the FIFO by the next cycle, clears the underflow flag and discards the remaining beats of a burst in flight. Fetching then resumes at the base address.
- R9: When `cfg_enable` falls during a burst, all of that burst's beats are still stored, and no further request is raised.
- R10: `px_pop` with the FIFO empty sets `px_underflow`, which stays set until a clear.
- R11: With the threshold set to depth − (2 × burst + 3), no beat is ever presented while the FIFO is full, and the level never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | ADDR_W | Byte address of the first frame word |
| cfg_frame_words | input | FRAME_W | Words per frame |
| cfg_burst_m1 | input | BLEN_W | Burst length minus one |
| cfg_threshold | input | LVL_W | Highest FIFO level at which a new burst may start |
| cfg_enable | input | 1 | Fetch enable |
| cfg_dma_clear | input | 1 | One-cycle clear strobe |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_len_m1 | output | BLEN_W | Burst length minus one |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |
| px_pop | input | 1 | Display side takes the head word |
| px_data | output | DATA_W | Head word of the FIFO |
| px_empty | output | 1 | FIFO holds no word |
| px_level | output | LVL_W | FIFO occupancy |
| px_underflow | output | 1 | Sticky flag for a read while empty |

## Verification
The assertions check the cycle-level rules on every cycle: a request holds steady until it is granted, a request never rises above the threshold or while disabled, bursts are never longer than the programmed length, a clear empties the FIFO, underflow is sticky, and no write is made into a full FIFO. Only the bench scenarios can show the data-level behaviour. These cover the address sequence over whole frames, with wrap and a truncated last burst; the order of the popped words; the settled fill level; the beats that still land after the enable falls; and the restart at the base address after a clear that arrives mid-burst.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   typedef enum logic [1:0] {
      FBF_IDLE = 2'd0,
      FBF_REQ  = 2'd1,
      FBF_DATA = 2'd2
   } fbf_state_e;
endpackage

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 512
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic                      wr_en,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      rd_en,
   output logic [DATA_W-1:0]         rd_data,
   output logic                      empty,
   output logic                      full,
   output logic [$clog2(DEPTH):0]    level
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   if ((1 << PTR_W) != DEPTH) begin : g_depth_chk
      $error("fbf_fifo: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              do_wr, do_rd;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign level   = cnt_q;
   assign do_wr   = wr_en && !full && !flush;
   assign do_rd   = rd_en && !empty && !flush;
   assign rd_data = store[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (do_wr) store[wr_ptr_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (flush) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_wr) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_rd) rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/fbf_addr_gen.sv
module fbf_addr_gen #(
   parameter int ADDR_W  = 32,
   parameter int FRAME_W = 24,
   parameter int BLEN_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               advance,
   input  logic [BLEN_W-1:0]  adv_len_m1,
   input  logic [ADDR_W-1:0]  base,
   input  logic [FRAME_W-1:0] frame_words,
   input  logic [BLEN_W-1:0]  burst_m1,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               has_work,
   output logic [BLEN_W-1:0]  next_len_m1
);
   logic [FRAME_W-1:0] offset_q;
   logic [FRAME_W-1:0] remaining;
   logic [FRAME_W-1:0] burst_words;
   logic [FRAME_W:0]   sum;
   logic               short_burst;

   assign remaining   = (offset_q < frame_words) ? (frame_words - offset_q) : '0;
   assign burst_words = FRAME_W'(burst_m1) + 1'b1;
   assign short_burst = (remaining < burst_words);
   assign has_work    = (remaining != '0);
   assign next_len_m1 = short_burst ? BLEN_W'(remaining - 1'b1) : burst_m1;
   assign sum         = {1'b0, offset_q} + (FRAME_W + 1)'(adv_len_m1) + 1'b1;
   assign mem_addr    = base + ADDR_W'({offset_q, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         offset_q <= '0;
      else if (clear)                     offset_q <= '0;
      else if (advance) begin
         if (sum >= {1'b0, frame_words}) offset_q <= '0;
         else                             offset_q <= sum[FRAME_W-1:0];
      end
   end
endmodule

// File: rtl/fbf_burst_ctrl.sv
module fbf_burst_ctrl
   import fbf_pkg::*;
#(
   parameter int BLEN_W = 4,
   parameter int LVL_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              clear,
   input  logic [LVL_W-1:0]  fill,
   input  logic [LVL_W-1:0]  threshold,
   input  logic              has_work,
   input  logic [BLEN_W-1:0] next_len_m1,
   input  logic              gnt,
   input  logic              rvalid,
   output logic              req,
   output logic [BLEN_W-1:0] len_m1,
   output logic              advance,
   output logic              fifo_wr
);
   fbf_state_e        state_q;
   logic [BLEN_W-1:0] len_q;
   logic [BLEN_W-1:0] beats_q;
   logic              drop_q;
   logic              last_beat;

   assign last_beat = (state_q == FBF_DATA) && rvalid && (beats_q == '0);
   assign req       = (state_q == FBF_REQ);
   assign len_m1    = len_q;
   assign advance   = req && gnt && !clear;
   assign fifo_wr   = (state_q == FBF_DATA) && rvalid && !drop_q && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FBF_IDLE;
         len_q   <= '0;
         beats_q <= '0;
         drop_q  <= 1'b0;
      end else begin
         case (state_q)
            FBF_IDLE: begin
               if (!clear && enable && has_work && (fill <= threshold)) begin
                  state_q <= FBF_REQ;
                  len_q   <= next_len_m1;
               end
            end
            FBF_REQ: begin
               if (clear) state_q <= FBF_IDLE;
               else if (gnt) begin
                  state_q <= FBF_DATA;
                  beats_q <= len_q;
                  drop_q  <= 1'b0;
               end
            end
            FBF_DATA: begin
               if (last_beat) begin
                  state_q <= FBF_IDLE;
                  drop_q  <= 1'b0;
               end else begin
                  if (rvalid) beats_q <= beats_q - 1'b1;
                  if (clear)  drop_q  <= 1'b1;
               end
            end
            default: state_q <= FBF_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fb_line_fetcher.sv
module fb_line_fetcher #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 512,
   parameter int FRAME_W    = 24,
   parameter int BLEN_W     = 4,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [FRAME_W-1:0] cfg_frame_words,
   input  logic [BLEN_W-1:0]  cfg_burst_m1,
   input  logic [LVL_W-1:0]   cfg_threshold,
   input  logic               cfg_enable,
   input  logic               cfg_dma_clear,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [BLEN_W-1:0]  mem_len_m1,
   input  logic               mem_gnt,
   input  logic               mem_rvalid,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               px_pop,
   output logic [DATA_W-1:0]  px_data,
   output logic               px_empty,
   output logic [LVL_W-1:0]   px_level,
   output logic               px_underflow
);
   if (FRAME_W <= BLEN_W) begin : g_frame_w_chk
      $error("fb_line_fetcher: FRAME_W must exceed BLEN_W");
   end
   if (ADDR_W <= FRAME_W + 2) begin : g_addr_w_chk
      $error("fb_line_fetcher: ADDR_W too small for FRAME_W");
   end
   if (FIFO_DEPTH < 16) begin : g_depth_chk
      $error("fb_line_fetcher: FIFO_DEPTH below 16");
   end

   logic              advance;
   logic              has_work;
   logic [BLEN_W-1:0] next_len_m1;
   logic              beat_wr;
   logic              fifo_full;
   logic              underflow_q;

   fbf_addr_gen #(
      .ADDR_W (ADDR_W),
      .FRAME_W(FRAME_W),
      .BLEN_W (BLEN_W)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (cfg_dma_clear),
      .advance    (advance),
      .adv_len_m1 (mem_len_m1),
      .base       (cfg_base),
      .frame_words(cfg_frame_words),
      .burst_m1   (cfg_burst_m1),
      .mem_addr   (mem_addr),
      .has_work   (has_work),
      .next_len_m1(next_len_m1)
   );

   fbf_burst_ctrl #(
      .BLEN_W(BLEN_W),
      .LVL_W (LVL_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cfg_enable),
      .clear      (cfg_dma_clear),
      .fill       (px_level),
      .threshold  (cfg_threshold),
      .has_work   (has_work),
      .next_len_m1(next_len_m1),
      .gnt        (mem_gnt),
      .rvalid     (mem_rvalid),
      .req        (mem_req),
      .len_m1     (mem_len_m1),
      .advance    (advance),
      .fifo_wr    (beat_wr)
   );

   fbf_fifo #(
      .DATA_W(DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (cfg_dma_clear),
      .wr_en  (beat_wr),
      .wr_data(mem_rdata),
      .rd_en  (px_pop),
      .rd_data(px_data),
      .empty  (px_empty),
      .full   (fifo_full),
      .level  (px_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  underflow_q <= 1'b0;
      else if (cfg_dma_clear)      underflow_q <= 1'b0;
      else if (px_pop && px_empty) underflow_q <= 1'b1;
   end
   assign px_underflow = underflow_q;
endmodule

// File: rtl/fb_line_fetcher_chk.sv
module fb_line_fetcher_chk #(
   parameter int ADDR_W     = 32,
   parameter int BLEN_W     = 4,
   parameter int FIFO_DEPTH = 512,
   parameter int LVL_W      = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BLEN_W-1:0] cfg_burst_m1,
   input logic [LVL_W-1:0]  cfg_threshold,
   input logic              cfg_enable,
   input logic              cfg_dma_clear,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [BLEN_W-1:0] mem_len_m1,
   input logic              mem_gnt,
   input logic              px_pop,
   input logic              px_empty,
   input logic [LVL_W-1:0]  px_level,
   input logic              px_underflow,
   input logic              beat_wr,
   input logic              fifo_full
);
   a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt && !cfg_dma_clear |=> mem_req && $stable(mem_addr) && $stable(mem_len_m1));

   a_r5_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(px_level) <= $past(cfg_threshold));

   a_r3_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_len_m1 <= cfg_burst_m1);

   a_r9_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable && !mem_req |=> !mem_req);

   a_r8_clear_flush: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dma_clear |=> px_level == '0 && !px_underflow);

   a_r10_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      px_pop && px_empty && !cfg_dma_clear |=> px_underflow);

   a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      px_underflow && !cfg_dma_clear |=> px_underflow);

   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      beat_wr |-> !fifo_full);

   a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      px_level <= LVL_W'(FIFO_DEPTH));
endmodule

bind fb_line_fetcher fb_line_fetcher_chk #(
   .ADDR_W    (ADDR_W),
   .BLEN_W    (BLEN_W),
   .FIFO_DEPTH(FIFO_DEPTH),
   .LVL_W     (LVL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_burst_m1 (cfg_burst_m1),
   .cfg_threshold(cfg_threshold),
   .cfg_enable   (cfg_enable),
   .cfg_dma_clear(cfg_dma_clear),
   .mem_req      (mem_req),
   .mem_addr     (mem_addr),
   .mem_len_m1   (mem_len_m1),
   .mem_gnt      (mem_gnt),
   .px_pop       (px_pop),
   .px_empty     (px_empty),
   .px_level     (px_level),
   .px_underflow (px_underflow),
   .beat_wr      (beat_wr),
   .fifo_full    (fifo_full)
);

// File: tb/test_fb_line_fetcher.sv
module test_fb_line_fetcher;
   localparam int AW = 32, DW = 32, DEPTH = 16, FW = 8, BLW = 3, LW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic [FW-1:0] cfg_frame_words = '0;
   logic [BLW-1:0] cfg_burst_m1 = '0;
   logic [LW-1:0] cfg_threshold = '0;
   logic          cfg_enable = 1'b0;
   logic          cfg_dma_clear = 1'b0;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic [BLW-1:0] mem_len_m1;
   logic          mem_gnt = 1'b0;
   logic          mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          px_pop = 1'b0;
   logic [DW-1:0] px_data;
   logic          px_empty;
   logic [LW-1:0] px_level;
   logic          px_underflow;

   always #5 clk = ~clk;

   fb_line_fetcher #(
      .ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(DEPTH), .FRAME_W(FW), .BLEN_W(BLW)
   ) i_fb_line_fetcher (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_frame_words(cfg_frame_words),
      .cfg_burst_m1(cfg_burst_m1), .cfg_threshold(cfg_threshold), .cfg_enable(cfg_enable),
      .cfg_dma_clear(cfg_dma_clear), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_len_m1(mem_len_m1), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .px_pop(px_pop), .px_data(px_data), .px_empty(px_empty),
      .px_level(px_level), .px_underflow(px_underflow)
   );

   int vectors = 0, fails = 0;
   bit done = 0;
   int cyc = 0;
   int cur_frame = 1, cur_burst = 1, cur_thr = 0;
   logic [31:0] cur_base = '0;
   int exp_req_off = 0, exp_pop_off = 0;
   int resp_left = 0, req_count = 0;
   bit resp_busy = 0;

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: grants after a short wait, returns beat data equal to its own address
   initial begin
      forever begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (mem_req) begin
            int goff, elen, lat;
            resp_busy = 1;
            goff = exp_req_off;
            elen = (cur_frame - goff < cur_burst) ? cur_frame - goff : cur_burst;
            lat  = req_count % 3;
            chk(int'(px_level) <= cur_thr, "R5 level when request raised", 32'(px_level), 32'(cur_thr));
            chk(int'(px_level) <= DEPTH, "R11 level bound", 32'(px_level), 32'(DEPTH));
            repeat (lat) @(negedge clk);
            chk(mem_addr == cur_base + 32'(4 * goff), "R2/R4 request address", mem_addr, cur_base + 32'(4 * goff));
            chk(int'(mem_len_m1) == elen - 1, "R3 burst length", 32'(mem_len_m1), 32'(elen - 1));
            mem_gnt = 1'b1;
            @(negedge clk);
            mem_gnt = 1'b0;
            exp_req_off = (goff + elen) % cur_frame;
            req_count++;
            for (int i = 0; i < elen; i++) begin
               if ((i + req_count) % 3 == 0) begin
                  mem_rvalid = 1'b0;
                  @(negedge clk);
               end
               mem_rvalid = 1'b1;
               mem_rdata  = cur_base + 32'(4 * (goff + i));
               resp_left  = elen - i;
               @(negedge clk);
            end
            mem_rvalid = 1'b0;
            resp_left  = 0;
            resp_busy  = 0;
         end
      end
   end

   task automatic pulse_clear();
      @(negedge clk);
      cfg_dma_clear = 1'b1;
      exp_req_off = 0;
      exp_pop_off = 0;
      @(negedge clk);
      cfg_dma_clear = 1'b0;
   endtask

   task automatic wait_quiet();
      repeat (2) @(negedge clk);
      while (resp_busy || mem_req) @(negedge clk);
   endtask

   // R7: pops n words with some backpressure, each must be the next frame word
   task automatic drain(input int n);
      int got = 0;
      while (got < n) begin
         @(negedge clk);
         px_pop = 1'b0;
         if (!px_empty && (cyc % 4 != 3)) begin
            chk(px_data == cur_base + 32'(4 * exp_pop_off), "R7 popped word order",
                px_data, cur_base + 32'(4 * exp_pop_off));
            px_pop = 1'b1;
            exp_pop_off = (exp_pop_off + 1) % cur_frame;
            got++;
         end
      end
      @(negedge clk);
      px_pop = 1'b0;
   endtask

   task automatic setup(input logic [31:0] base, input int burst, input int frame, input int thr);
      cfg_enable = 1'b0;
      wait_quiet();
      pulse_clear();
      cur_base = base; cur_burst = burst; cur_frame = frame; cur_thr = thr;
      cfg_base = base;
      cfg_burst_m1 = BLW'(burst - 1);
      cfg_frame_words = FW'(frame);
      cfg_threshold = LW'(thr);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int frames[6] = '{1, 3, 5, 8, 13, 20};
      int idx = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mem_req == 1'b0, "R1 no request", 32'(mem_req), 0);
      chk(px_empty == 1'b1, "R1 fifo empty", 32'(px_empty), 1);
      chk(px_level == '0, "R1 level zero", 32'(px_level), 0);
      chk(px_underflow == 1'b0, "R1 underflow clear", 32'(px_underflow), 0);

      // sweep: burst lengths x frame lengths, threshold from the depth formula (R11)
      for (int b = 1; b <= 6; b++) begin
         foreach (frames[f]) begin
            idx++;
            setup(32'h0001_0000 * idx, b, frames[f], DEPTH - (2 * b + 3));
            cfg_enable = 1'b1;
            drain(3 * frames[f] + 4);
            cfg_enable = 1'b0;
         end
      end

      // R5 settled level with no reads: smallest multiple of burst above threshold
      for (int k = 0; k < 4; k++) begin
         int bl, th, expl;
         bl = (k == 0) ? 4 : (k == 1) ? 4 : (k == 2) ? 6 : 2;
         th = (k == 0) ? 5 : (k == 1) ? 9 : (k == 2) ? 5 : 0;
         expl = (th / bl + 1) * bl;
         setup(32'h0020_0000, bl, 200, th);
         cfg_enable = 1'b1;
         repeat (80) @(negedge clk);
         chk(int'(px_level) == expl, "R5 settled level", 32'(px_level), 32'(expl));
         drain(expl);
         cfg_enable = 1'b0;
      end

      // R9: drop enable during a burst
      begin
         int l0, rl, seen;
         setup(32'h0030_0000, 4, 200, 11);
         cfg_enable = 1'b1;
         do begin @(negedge clk); #1; end while (!mem_rvalid);
         cfg_enable = 1'b0;
         l0 = int'(px_level);
         rl = resp_left;
         seen = 0;
         repeat (60) begin
            @(negedge clk);
            if (mem_req && !resp_busy) seen++;
         end
         chk(seen == 0, "R9 no request after disable", 32'(seen), 0);
         chk(int'(px_level) == l0 + rl, "R9 burst completed", 32'(px_level), 32'(l0 + rl));
      end

      // R8: clear in the middle of a burst
      setup(32'h0040_0000, 4, 40, 5);
      cfg_enable = 1'b1;
      do begin @(negedge clk); #1; end while (!(mem_rvalid && resp_left == 2));
      cfg_dma_clear = 1'b1;
      exp_req_off = 0;
      exp_pop_off = 0;
      @(negedge clk);
      cfg_dma_clear = 1'b0;
      chk(px_level == '0, "R8 fifo flushed", 32'(px_level), 0);
      drain(12);
      cfg_enable = 1'b0;

      // R10: underflow is sticky, R8 clear removes it
      wait_quiet();
      pulse_clear();
      @(negedge clk);
      px_pop = 1'b1;
      @(negedge clk);
      px_pop = 1'b0;
      chk(px_underflow == 1'b1, "R10 underflow set", 32'(px_underflow), 1);
      chk(px_level == '0, "R10 level unchanged", 32'(px_level), 0);
      repeat (5) @(negedge clk);
      chk(px_underflow == 1'b1, "R10 underflow sticky", 32'(px_underflow), 1);
      pulse_clear();
      chk(px_underflow == 1'b0, "R8 clear removes underflow", 32'(px_underflow), 0);

      done = 1;
      summary();
      $finish;
   end
endmodule